// File: doc/BRIEF.md
# Self-Reconfiguring TMR Voter

This block votes one signal group of a triple-redundant machine. Three channel copies of a data word enter, and a registered word leaves that is the bitwise two-of-three majority of the three voting slots. A comparator watches the slots on every clock and raises a mismatch flag when they do not all agree. When exactly one slot differs from the other two, it names that channel. If no two slots agree, it flags an uncorrectable error and holds the last good word.

On a strobe pulse the block samples its fault evidence. Reconfiguration happens only when the same evidence appears on two consecutive strobe samples. A failing channel is first replaced by a fourth wired-in spare channel when the spare is allowed and still unused, so three-way voting goes on. Otherwise the faulty channel and one good channel are switched off, and the remaining channel is passed straight through. In simplex, comparison is no longer possible, so an external per-channel fault input condemns the active channel. If standby reuse is allowed, the output then moves to the good channel that was switched off earlier. Otherwise the block enters a failed state and holds its output.

A manual override steers the output to a chosen channel and freezes the automatic logic. A manual reset pulse returns the block to full three-way voting with all flags cleared, without stopping the clock.

Top module: `tmr_reconfig_voter`

## Requirements
- R1: In mode TMR the output `voted`, one clock after the inputs, equals the bitwise two-of-three majority of the three voting slots. At reset slot 0, 1 and 2 take channels a, b and c.
- R2: In mode TMR, `mismatch` is 1 one clock after any cycle in which the three slots are not all equal, and 0 otherwise. Voting goes on while it is set.
- R3: `odd_ch` is one-hot by physical channel (bit 0 = a, 1 = b, 2 = c, 3 = spare). One clock after a TMR cycle in which exactly one slot differs from two equal ones, it marks that slot's channel. Otherwise it is 0.
- R4: When the spare is not available, a confirmed odd slot sets its channel's bit in `ch_fail` and `mode` becomes SIMPLEX (1). The channel of the lower-numbered remaining good slot becomes active and alone in `ch_en`, and `voted` follows it with one clock of delay.
- R5: When the active simplex channel is condemned and `standby_en` is 1, the channel of the higher-numbered good slot becomes active and `mode` becomes SPARE_ACTIVE (2). When `standby_en` is 0, or a second channel is condemned, `mode` becomes FAILED (3), `ch_en` becomes 0 and `voted` holds.
- R6: With `spare_en` set and the spare unused, a confirmed odd slot is refilled from the spare channel. `mode` stays TMR (0), `ch_en` bit 3 is set and the failed channel's bit is cleared, and the spare takes part in voting and comparison.
- R7: While `ovr_en` is 1, `voted` takes the channel numbered `ovr_sel` one clock later, and no reconfiguration happens.
- R8: A `man_rst` pulse returns the block to TMR with `ch_en` = 0111 and `ch_fail` = 0. From the next clock the output votes channels a, b and c again.
- R9: A reconfiguration needs the same fault evidence on two consecutive strobe samples. A strobe sample without that evidence cancels the pending fault. Cycles without a strobe change nothing.
- R10: `ch_fail` bits, once set, stay set until `man_rst` or `rst_n`.
- R11: In mode TMR, when no two slots are equal, `uncorrectable` and `mismatch` are 1 one clock later, `odd_ch` is 0 and `voted` holds its previous value.
- R12: In SIMPLEX or SPARE_ACTIVE, the fault evidence is `ext_fault` bit of the active channel on the strobe. Two consecutive such samples condemn the active channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_a | input | W | Channel 0 data |
| ch_b | input | W | Channel 1 data |
| ch_c | input | W | Channel 2 data |
| ch_spare | input | W | Channel 3, the wired-in spare |
| sample | input | 1 | Strobe: one-cycle pulse that samples fault evidence |
| ext_fault | input | 4 | Per-channel external fault indication, used in simplex |
| spare_en | input | 1 | Allow the spare channel to refill a failed slot |
| standby_en | input | 1 | Keep the switched-off good channel as a standby |
| ovr_en | input | 1 | Manual override of the output and the automatic logic |
| ovr_sel | input | 2 | Channel selected by the override |
| man_rst | input | 1 | Manual return to full voting, clears all flags |
| voted | output | W | Registered voted output |
| mismatch | output | 1 | Slots disagree |
| uncorrectable | output | 1 | No two slots agree, output held |
| odd_ch | output | 4 | One-hot physical channel that differs |
| mode | output | 2 | 0 TMR, 1 SIMPLEX, 2 SPARE_ACTIVE, 3 FAILED |
| ch_en | output | 4 | Channels that currently drive the output |
| ch_fail | output | 4 | Sticky failed-channel flags |

## Verification
The confirming strobe and the output update land on the same clock edge. In that cycle the status ports (`mode`, `ch_en`, `ch_fail`) already show the new configuration, while `voted` still carries the word voted under the old one. The bench provokes this by repeating a single-slot disagreement, and later an external fault, on two strobes. At the edge of the second strobe it expects the new status together with the old-configuration output, then the new source on the following cycle. Override and a pending external fault are also applied together, and the bench expects the override to win: the output follows the selected channel, the mode stays unchanged, and the fault count restarts once the override is released.

// File: rtl/tmr_voter_pkg.sv
// Package: shared types and helpers for the reconfiguring voter.
// Assumes channel numbering 0..2 for the main channels and 3 for the spare.
package tmr_voter_pkg;

    typedef enum logic [1:0] {
        MODE_TMR          = 2'd0,
        MODE_SIMPLEX      = 2'd1,
        MODE_SPARE_ACTIVE = 2'd2,
        MODE_FAILED       = 2'd3
    } vmode_t;

    localparam int NUM_CH    = 4;
    localparam int NUM_SLOTS = 3;
    localparam int CH_IDX_W  = $clog2(NUM_CH);

    // Turns a channel number into a one-hot channel mask.
    function automatic logic [NUM_CH-1:0] ch_onehot(input logic [CH_IDX_W-1:0] idx);
        return {{(NUM_CH-1){1'b0}}, 1'b1} << idx;
    endfunction

endpackage

// File: rtl/tmr_vote_core.sv
// Vote core: routes channels into three voting slots, forms the bitwise
// majority and classifies the agreement pattern at word level.
// Assumes slot_src never selects one channel for two slots.
module tmr_vote_core
    import tmr_voter_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NUM_CH-1:0][W-1:0]      chans,
    input  logic [NUM_SLOTS-1:0][CH_IDX_W-1:0] slot_src,
    output logic [W-1:0]                  maj,
    output logic                          disagree,
    output logic                          odd_valid,
    output logic                          no_majority,
    output logic [1:0]                    odd_slot
);

    logic [NUM_SLOTS-1:0][W-1:0] slot_val;
    logic eq01, eq02, eq12;

    genvar s, b;
    generate
        // Per-slot source multiplexer.
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign slot_val[s] = chans[slot_src[s]];
        end
        // Per-bit two-of-three majority.
        for (b = 0; b < W; b++) begin : g_bit
            assign maj[b] = (slot_val[0][b] & slot_val[1][b]) |
                            (slot_val[0][b] & slot_val[2][b]) |
                            (slot_val[1][b] & slot_val[2][b]);
        end
    endgenerate

    // Word-level agreement classification.
    always_comb begin
        eq01        = (slot_val[0] == slot_val[1]);
        eq02        = (slot_val[0] == slot_val[2]);
        eq12        = (slot_val[1] == slot_val[2]);
        disagree    = !(eq01 && eq12);
        no_majority = !eq01 && !eq02 && !eq12;
        odd_valid   = disagree && !no_majority;
        if (eq01)      odd_slot = 2'd2;
        else if (eq02) odd_slot = 2'd1;
        else           odd_slot = 2'd0;
    end

endmodule

// File: rtl/tmr_persist.sv
// Persistence filter: fires when the same candidate is seen with its
// condition true on two consecutive strobe samples.
// Assumes cond and cand are stable around the strobe cycle.
module tmr_persist #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sample,
    input  logic          cond,
    input  logic [CW-1:0] cand,
    output logic          fire
);

    logic          pend_q;
    logic [CW-1:0] pend_cand_q;

    assign fire = sample && cond && pend_q && (cand == pend_cand_q);

    // Remembers the evidence of the previous strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_cand_q <= '0;
        end else if (clr || fire) begin
            pend_q      <= 1'b0;
        end else if (sample) begin
            pend_q      <= cond;
            pend_cand_q <= cand;
        end
    end

endmodule

// File: rtl/tmr_reconfig_ctl.sv
// Reconfiguration controller: holds the operating mode, the slot-to-channel
// map, the active and standby simplex channels and the sticky failure flags.
// Assumes fire is a single-cycle pulse and that fire_cand is the odd slot in
// TMR (it is ignored in the other modes).
module tmr_reconfig_ctl
    import tmr_voter_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               man_rst,
    input  logic                               fire,
    input  logic [1:0]                         fire_cand,
    input  logic                               spare_en,
    input  logic                               standby_en,
    output vmode_t                             mode,
    output logic [NUM_SLOTS-1:0][CH_IDX_W-1:0] slot_src,
    output logic [CH_IDX_W-1:0]                act_ch,
    output logic [NUM_CH-1:0]                  ch_fail,
    output logic [NUM_CH-1:0]                  ch_en
);

    localparam logic [NUM_SLOTS-1:0][CH_IDX_W-1:0] SRC_INIT = {2'd2, 2'd1, 2'd0};
    localparam logic [CH_IDX_W-1:0] SPARE_IDX = CH_IDX_W'(NUM_CH - 1);

    vmode_t                             mode_q;
    logic [NUM_SLOTS-1:0][CH_IDX_W-1:0] src_q;
    logic [CH_IDX_W-1:0]                act_q, stby_q;
    logic [NUM_CH-1:0]                  fail_q;
    logic                               spare_used_q;
    logic [1:0]                         g_lo, g_hi;
    logic [CH_IDX_W-1:0]                odd_phys;

    // Picks the two good slots left when fire_cand is dropped.
    always_comb begin
        case (fire_cand)
            2'd0:    begin g_lo = 2'd1; g_hi = 2'd2; end
            2'd1:    begin g_lo = 2'd0; g_hi = 2'd2; end
            default: begin g_lo = 2'd0; g_hi = 2'd1; end
        endcase
        odd_phys = src_q[fire_cand];
    end

    // Mode and map update on a confirmed fault or a manual reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= MODE_TMR;
            src_q        <= SRC_INIT;
            act_q        <= '0;
            stby_q       <= '0;
            fail_q       <= '0;
            spare_used_q <= 1'b0;
        end else if (man_rst) begin
            mode_q       <= MODE_TMR;
            src_q        <= SRC_INIT;
            act_q        <= '0;
            stby_q       <= '0;
            fail_q       <= '0;
            spare_used_q <= 1'b0;
        end else if (fire) begin
            case (mode_q)
                MODE_TMR: begin
                    fail_q[odd_phys] <= 1'b1;
                    if (spare_en && !spare_used_q) begin
                        src_q[fire_cand] <= SPARE_IDX;
                        spare_used_q     <= 1'b1;
                    end else begin
                        act_q  <= src_q[g_lo];
                        stby_q <= src_q[g_hi];
                        mode_q <= MODE_SIMPLEX;
                    end
                end
                MODE_SIMPLEX: begin
                    fail_q[act_q] <= 1'b1;
                    if (standby_en) begin
                        act_q  <= stby_q;
                        mode_q <= MODE_SPARE_ACTIVE;
                    end else begin
                        mode_q <= MODE_FAILED;
                    end
                end
                MODE_SPARE_ACTIVE: begin
                    fail_q[act_q] <= 1'b1;
                    mode_q        <= MODE_FAILED;
                end
                default: mode_q <= MODE_FAILED;
            endcase
        end
    end

    // Channel enables derived from the current configuration.
    always_comb begin
        case (mode_q)
            MODE_TMR:    ch_en = ch_onehot(src_q[0]) | ch_onehot(src_q[1]) |
                                 ch_onehot(src_q[2]);
            MODE_FAILED: ch_en = '0;
            default:     ch_en = ch_onehot(act_q);
        endcase
    end

    assign mode     = mode_q;
    assign slot_src = src_q;
    assign act_ch   = act_q;
    assign ch_fail  = fail_q;

endmodule

// File: rtl/tmr_reconfig_voter.sv
// Top: self-reconfiguring voter for one signal group. Combines the vote
// core, the persistence filter and the controller, and registers every
// data and flag output. Assumes sample is a one-cycle pulse and ovr_sel
// names a wired channel.
module tmr_reconfig_voter
    import tmr_voter_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ch_a,
    input  logic [W-1:0] ch_b,
    input  logic [W-1:0] ch_c,
    input  logic [W-1:0] ch_spare,
    input  logic         sample,
    input  logic [3:0]   ext_fault,
    input  logic         spare_en,
    input  logic         standby_en,
    input  logic         ovr_en,
    input  logic [1:0]   ovr_sel,
    input  logic         man_rst,
    output logic [W-1:0] voted,
    output logic         mismatch,
    output logic         uncorrectable,
    output logic [3:0]   odd_ch,
    output logic [1:0]   mode,
    output logic [3:0]   ch_en,
    output logic [3:0]   ch_fail
);

    logic [NUM_CH-1:0][W-1:0]           chans;
    logic [NUM_SLOTS-1:0][CH_IDX_W-1:0] slot_src;
    logic [W-1:0]                       maj, voted_d, voted_q;
    logic                               disagree, odd_valid, no_majority;
    logic [1:0]                         odd_slot;
    logic [CH_IDX_W-1:0]                act_ch;
    vmode_t                             mode_s;
    logic                               cond, fire;
    logic [1:0]                         cand;
    logic                               mm_q, ue_q;
    logic [NUM_CH-1:0]                  odd_q, odd_d;

    assign chans = {ch_spare, ch_c, ch_b, ch_a};

    tmr_vote_core #(.W(W)) u_core (
        .chans       (chans),
        .slot_src    (slot_src),
        .maj         (maj),
        .disagree    (disagree),
        .odd_valid   (odd_valid),
        .no_majority (no_majority),
        .odd_slot    (odd_slot)
    );

    // Fault evidence per mode, suspended by the override.
    always_comb begin
        case (mode_s)
            MODE_TMR: begin
                cond = disagree && odd_valid;
                cand = odd_slot;
            end
            MODE_SIMPLEX, MODE_SPARE_ACTIVE: begin
                cond = ext_fault[act_ch];
                cand = act_ch;
            end
            default: begin
                cond = 1'b0;
                cand = 2'd0;
            end
        endcase
        if (ovr_en) cond = 1'b0;
    end

    tmr_persist #(.CW(2)) u_persist (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (man_rst),
        .sample (sample),
        .cond   (cond),
        .cand   (cand),
        .fire   (fire)
    );

    tmr_reconfig_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .man_rst    (man_rst),
        .fire       (fire),
        .fire_cand  (odd_slot),
        .spare_en   (spare_en),
        .standby_en (standby_en),
        .mode       (mode_s),
        .slot_src   (slot_src),
        .act_ch     (act_ch),
        .ch_fail    (ch_fail),
        .ch_en      (ch_en)
    );

    // Next output word: override, vote, pass-through or hold.
    always_comb begin
        if (ovr_en) begin
            voted_d = chans[ovr_sel];
        end else begin
            case (mode_s)
                MODE_TMR:    voted_d = no_majority ? voted_q : maj;
                MODE_FAILED: voted_d = voted_q;
                default:     voted_d = chans[act_ch];
            endcase
        end
        odd_d = (mode_s == MODE_TMR && odd_valid) ? ch_onehot(slot_src[odd_slot]) : '0;
    end

    // Output and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            voted_q <= '0;
            mm_q    <= 1'b0;
            ue_q    <= 1'b0;
            odd_q   <= '0;
        end else begin
            voted_q <= voted_d;
            mm_q    <= (mode_s == MODE_TMR) && disagree;
            ue_q    <= (mode_s == MODE_TMR) && no_majority;
            odd_q   <= odd_d;
        end
    end

    assign voted         = voted_q;
    assign mismatch      = mm_q;
    assign uncorrectable = ue_q;
    assign odd_ch        = odd_q;
    assign mode          = mode_s;

endmodule

// File: rtl/tmr_reconfig_voter_chk.sv
// Checker: temporal properties of the voter, attached through bind.
// Assumes it sees the top-level ports of tmr_reconfig_voter.
module tmr_reconfig_voter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] ch_a,
    input logic         sample,
    input logic         ovr_en,
    input logic         man_rst,
    input logic [W-1:0] voted,
    input logic         mismatch,
    input logic         uncorrectable,
    input logic [3:0]   odd_ch,
    input logic [1:0]   mode,
    input logic [3:0]   ch_en,
    input logic [3:0]   ch_fail
);

    // With the initial map, an agreeing TMR cycle yields channel a.
    assert_vote_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'd0 && $past(ch_en) == 4'b0111 &&
         !$past(ovr_en) && !mismatch) |-> voted == $past(ch_a));

    assert_uncorr_implies_mm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |-> mismatch);

    assert_odd_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(odd_ch));

    assert_odd_needs_majority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_ch != 4'b0) |-> (mismatch && !uncorrectable));

    assert_single_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 || mode == 2'd2) |-> $countones(ch_en) == 1);

    assert_failed_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> ch_en == 4'b0);

    assert_three_voters_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> $countones(ch_en) == 3);

    assert_override_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ovr_en) && !$past(man_rst)) |-> mode == $past(mode));

    assert_no_strobe_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sample) && !$past(man_rst)) |-> ch_fail == $past(ch_fail));

    assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(man_rst)) |-> (ch_fail & $past(ch_fail)) == $past(ch_fail));

    assert_hold_on_uncorr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && uncorrectable && !$past(ovr_en)) |-> voted == $past(voted));

endmodule

bind tmr_reconfig_voter tmr_reconfig_voter_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ch_a          (ch_a),
    .sample        (sample),
    .ovr_en        (ovr_en),
    .man_rst       (man_rst),
    .voted         (voted),
    .mismatch      (mismatch),
    .uncorrectable (uncorrectable),
    .odd_ch        (odd_ch),
    .mode          (mode),
    .ch_en         (ch_en),
    .ch_fail       (ch_fail)
);

// File: tb/tmr_reconfig_voter_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one cycle of stimulus at the falling
// edge and queues the outputs expected after the next rising edge; the
// monitor pops and compares one item after each rising edge.
module tmr_reconfig_voter_tb;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] v;
        logic         mm;
        logic         ue;
        logic [1:0]   md;
        logic [3:0]   od;
        logic [3:0]   en;
        logic [3:0]   fl;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] ch_a, ch_b, ch_c, ch_spare;
    logic         sample, spare_en, standby_en, ovr_en, man_rst;
    logic [3:0]   ext_fault;
    logic [1:0]   ovr_sel;
    logic [W-1:0] voted;
    logic         mismatch, uncorrectable;
    logic [3:0]   odd_ch, ch_en, ch_fail;
    logic [1:0]   mode;

    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    tmr_reconfig_voter #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c),
        .ch_spare(ch_spare), .sample(sample), .ext_fault(ext_fault),
        .spare_en(spare_en), .standby_en(standby_en), .ovr_en(ovr_en),
        .ovr_sel(ovr_sel), .man_rst(man_rst), .voted(voted),
        .mismatch(mismatch), .uncorrectable(uncorrectable), .odd_ch(odd_ch),
        .mode(mode), .ch_en(ch_en), .ch_fail(ch_fail)
    );

    // Applies one cycle of stimulus and queues the expected outputs.
    task automatic drive(input logic [W-1:0] a, b, c, s, input logic smp,
                         input logic [3:0] flt, input logic [W-1:0] ev,
                         input logic emm, eue, input logic [1:0] emd,
                         input logic [3:0] eod, een, efl, input string tag);
        exp_t e;
        ch_a = a; ch_b = b; ch_c = c; ch_spare = s;
        sample = smp; ext_fault = flt;
        e.v = ev; e.mm = emm; e.ue = eue; e.md = emd;
        e.od = eod; e.en = een; e.fl = efl; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compares outputs one time unit after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                tests++;
                if (voted !== e.v || mismatch !== e.mm || uncorrectable !== e.ue ||
                    mode !== e.md || odd_ch !== e.od || ch_en !== e.en ||
                    ch_fail !== e.fl) begin
                    fails++;
                    $display("FAIL %s: got v=%h mm=%b ue=%b md=%0d od=%b en=%b fl=%b, exp v=%h mm=%b ue=%b md=%0d od=%b en=%b fl=%b",
                             e.tag, voted, mismatch, uncorrectable, mode, odd_ch, ch_en, ch_fail,
                             e.v, e.mm, e.ue, e.md, e.od, e.en, e.fl);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ch_a = '0; ch_b = '0; ch_c = '0; ch_spare = '0;
        sample = 1'b0; ext_fault = '0; spare_en = 1'b0; standby_en = 1'b0;
        ovr_en = 1'b0; ovr_sel = 2'd0; man_rst = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R8 state values).
        tests++;
        if (voted !== 8'h00 || mode !== 2'd0 || ch_en !== 4'b0111 || ch_fail !== 4'b0 ||
            mismatch !== 1'b0 || uncorrectable !== 1'b0 || odd_ch !== 4'b0) begin
            fails++;
            $display("FAIL R8 reset: got v=%h md=%0d en=%b fl=%b, exp v=00 md=0 en=0111 fl=0000",
                     voted, mode, ch_en, ch_fail);
        end

        // Scenario 1: no spare, no standby.
        drive(8'h5A,8'h5A,8'h5A,8'h00,0,4'h0, 8'h5A,0,0,2'd0,4'h0,4'h7,4'h0,"R1 agree");
        drive(8'h3C,8'h3C,8'hC3,8'h00,0,4'h0, 8'h3C,1,0,2'd0,4'h4,4'h7,4'h0,"R2 c odd");
        drive(8'h3C,8'h3C,8'hC3,8'h00,1,4'h0, 8'h3C,1,0,2'd0,4'h4,4'h7,4'h0,"R9 first sample");
        drive(8'h3C,8'h3C,8'h3C,8'h00,1,4'h0, 8'h3C,0,0,2'd0,4'h0,4'h7,4'h0,"R9 clean sample");
        drive(8'h3C,8'h3C,8'hC3,8'h00,1,4'h0, 8'h3C,1,0,2'd0,4'h4,4'h7,4'h0,"R9 restart");
        drive(8'h11,8'h22,8'h33,8'h00,0,4'h0, 8'h3C,1,1,2'd0,4'h0,4'h7,4'h0,"R11 hold");
        drive(8'h3C,8'h3C,8'hC3,8'h00,1,4'h0, 8'h3C,1,0,2'd1,4'h4,4'h1,4'h4,"R4 drop to simplex");
        drive(8'h77,8'h88,8'h99,8'h00,0,4'h0, 8'h77,0,0,2'd1,4'h0,4'h1,4'h4,"R4 pass a");
        drive(8'h12,8'h88,8'h99,8'h00,1,4'h1, 8'h12,0,0,2'd1,4'h0,4'h1,4'h4,"R12 first fault");
        drive(8'h13,8'h88,8'h99,8'h00,1,4'h1, 8'h13,0,0,2'd3,4'h0,4'h0,4'h5,"R12 condemned");
        drive(8'h99,8'h99,8'h99,8'h00,1,4'h0, 8'h13,0,0,2'd3,4'h0,4'h0,4'h5,"R10 sticky");
        drive(8'h99,8'h99,8'h99,8'h00,0,4'h0, 8'h13,0,0,2'd3,4'h0,4'h0,4'h5,"R5 failed holds");
        man_rst = 1'b1;
        drive(8'h44,8'h44,8'h44,8'h00,0,4'h0, 8'h13,0,0,2'd0,4'h0,4'h7,4'h0,"R8 manual reset");
        man_rst = 1'b0;
        drive(8'h44,8'h44,8'h44,8'h00,0,4'h0, 8'h44,0,0,2'd0,4'h0,4'h7,4'h0,"R8 back in service");

        // Scenario 2: standby reuse.
        standby_en = 1'b1;
        drive(8'h3C,8'h3C,8'hC3,8'h00,1,4'h0, 8'h3C,1,0,2'd0,4'h4,4'h7,4'h0,"R9 pending");
        drive(8'h3C,8'h3C,8'hC3,8'h00,1,4'h0, 8'h3C,1,0,2'd1,4'h4,4'h1,4'h4,"R4 simplex with standby");
        drive(8'h12,8'h34,8'h99,8'h00,1,4'h1, 8'h12,0,0,2'd1,4'h0,4'h1,4'h4,"R12 first fault");
        drive(8'h12,8'h34,8'h99,8'h00,1,4'h1, 8'h12,0,0,2'd2,4'h0,4'h2,4'h5,"R5 switch to standby");
        drive(8'h00,8'h56,8'h99,8'h00,0,4'h0, 8'h56,0,0,2'd2,4'h0,4'h2,4'h5,"R5 standby drives");
        drive(8'h00,8'h57,8'h99,8'h00,1,4'h2, 8'h57,0,0,2'd2,4'h0,4'h2,4'h5,"R12 standby fault 1");
        drive(8'h00,8'h58,8'h99,8'h00,1,4'h2, 8'h58,0,0,2'd3,4'h0,4'h0,4'h7,"R5 second loss");
        man_rst = 1'b1;
        drive(8'h00,8'h58,8'h99,8'h00,0,4'h0, 8'h58,0,0,2'd0,4'h0,4'h7,4'h0,"R8 manual reset 2");
        man_rst = 1'b0;

        // Scenario 3: fourth spare channel.
        standby_en = 1'b0;
        spare_en   = 1'b1;
        drive(8'h21,8'hDE,8'h21,8'h21,1,4'h0, 8'h21,1,0,2'd0,4'h2,4'h7,4'h0,"R3 b odd");
        drive(8'h21,8'hDE,8'h21,8'h21,1,4'h0, 8'h21,1,0,2'd0,4'h2,4'hD,4'h2,"R6 spare replaces b");
        drive(8'h40,8'hFF,8'h40,8'h40,0,4'h0, 8'h40,0,0,2'd0,4'h0,4'hD,4'h2,"R6 b ignored");
        drive(8'h40,8'h40,8'h40,8'hBF,0,4'h0, 8'h40,1,0,2'd0,4'h8,4'hD,4'h2,"R6 spare compared");
        drive(8'h0F,8'h00,8'h40,8'h40,1,4'h0, 8'h40,1,0,2'd0,4'h1,4'hD,4'h2,"R6 a odd");
        drive(8'h0F,8'h00,8'h40,8'h40,1,4'h0, 8'h40,1,0,2'd1,4'h1,4'h8,4'h3,"R4 simplex on spare");
        drive(8'h0F,8'h00,8'h77,8'h66,0,4'h0, 8'h66,0,0,2'd1,4'h0,4'h8,4'h3,"R4 spare passes");
        ovr_en = 1'b1; ovr_sel = 2'd2;
        drive(8'h0F,8'h00,8'h77,8'h66,1,4'h8, 8'h77,0,0,2'd1,4'h0,4'h8,4'h3,"R7 override select");
        drive(8'h0F,8'h00,8'h77,8'h66,1,4'h8, 8'h77,0,0,2'd1,4'h0,4'h8,4'h3,"R7 override freezes");
        ovr_en = 1'b0;
        drive(8'h0F,8'h00,8'h77,8'h66,1,4'h8, 8'h66,0,0,2'd1,4'h0,4'h8,4'h3,"R12 count restarts");
        drive(8'h0F,8'h00,8'h77,8'h66,1,4'h8, 8'h66,0,0,2'd3,4'h0,4'h0,4'hB,"R12 spare condemned");

        sample = 1'b0; ext_fault = '0;
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL scoreboard: got %0d pending, exp 0", q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule